// File: doc/BRIEF.md
# Receive tap delay tuning engine

This block chooses the sampling point of a receive data path. It sweeps a 32-position programmable input delay line and keeps the tap that sits in the middle of the passing region. A start pulse launches the sweep. For each tap, the engine loads the tap into the delay line and then asks an external tester to run one tuning trial. The tester answers with a valid strobe and a pass/fail bit. Each answer updates a running fail count and the start of the passing window.

Every change to the tap value happens inside a change window. The window strobe rises one cycle before the tap changes and falls one cycle after it. When the last tap has been tried, the engine treats the tap range as a ring. It takes the window length as the tap count minus the fails and places the final tap half a window past the recorded start. A window that wraps past tap 31 into tap 0 is therefore centred correctly. The final tap is written with the same bracketed sequence. The engine then reports completion and the chosen tap.

Top module: `rx_tap_tuner`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared: `busy`, `done`, `dly_en`, `chg_win`, `trial_req` and `degenerate` are 0, and `tap_sel` and `result_tap` are 0.
- R2: A `start` pulse seen while idle sets `busy` and `dly_en` on the same edge, before any tap write. `dly_en` then stays high through the sweep and after it, until reset.
- R3: `tap_sel` changes only in a cycle where `chg_win` was already high on the previous cycle and is still high. `chg_win` drops on the cycle after the change. `trial_req` is never high while `chg_win` is high.
- R4: The sweep issues exactly one trial per tap, for taps 0, 1, ..., 31 in that order. `tap_sel` holds the tap under trial. `trial_req` stays high until a cycle in which `trial_valid` is high, and `trial_pass` (1 = pass) is sampled in that cycle.
- R5: The previous result starts as pass. A passing tap that follows a failing tap records its index as the window start, and the last such edge wins. If tap 0 passes, it is not a window start.
- R6: The final tap is (window start + ((32 - fail count) >> 1)) mod 32. It is applied to `tap_sel` through the bracketed write of R3 and is shown on `result_tap`.
- R7: After the final write, `done` rises and `busy` falls on the same edge. `done` holds until the next accepted start.
- R8: If all taps pass, the result is 16. If all taps fail, the result is 0. In both cases `degenerate` is 1 while `done` is high; otherwise it is 0.
- R9: A `start` pulse while `busy` is high has no effect on the sweep or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a sweep (accepted only when idle) |
| trial_valid | input | 1 | Tester result strobe |
| trial_pass | input | 1 | Tester result, 1 = pass |
| trial_req | output | 1 | Request one tuning trial at the current tap |
| tap_sel | output | 5 | Delay line tap select |
| chg_win | output | 1 | Tap change window strobe |
| dly_en | output | 1 | Input delay enable |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished, result valid |
| result_tap | output | 5 | Chosen tap |
| degenerate | output | 1 | All taps passed or all failed |

## Verification
The bound checker watches four things on every cycle: tap changes only inside an open change window, no trial request overlaps that window, a request is held until it is answered, and done and busy are exclusive, with the delay enable covering the whole busy period. Only the bench's scenarios can show the results. These are the visiting order of the taps, the window-start edge rule and its treatment of tap 0, the circular centring of wrapping and split windows, the two degenerate sweeps, and the fact that a start during a sweep leaves the chosen tap unchanged.

// File: rtl/rx_tap_tuner.sv
module rx_tap_tuner #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             trial_valid,
  input  logic             trial_pass,
  output logic             trial_req,
  output logic [TAP_W-1:0] tap_sel,
  output logic             chg_win,
  output logic             dly_en,
  output logic             busy,
  output logic             done,
  output logic [TAP_W-1:0] result_tap,
  output logic             degenerate
);
  localparam int NTAPS = 1 << TAP_W;
  localparam int CNT_W = TAP_W + 1;
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NTAPS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NTAPS);

  typedef enum logic [2:0] {
    S_IDLE, S_OPEN, S_WRITE, S_CLOSE, S_TRIAL, S_CALC
  } state_t;

  state_t           state;
  logic [TAP_W-1:0] cur_tap;
  logic [TAP_W-1:0] target;
  logic [TAP_W-1:0] win_start;
  logic [CNT_W-1:0] fail_cnt;
  logic             prev_pass;
  logic             final_ph;

  logic [CNT_W-1:0] pass_len;
  logic [CNT_W-1:0] half_len;
  logic [TAP_W-1:0] centre;
  logic             accept;

  assign pass_len = FULL_CNT - fail_cnt;
  assign half_len = pass_len >> 1;
  assign centre   = win_start + half_len[TAP_W-1:0];
  assign accept   = trial_req && trial_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_tap    <= '0;
      target     <= '0;
      win_start  <= '0;
      fail_cnt   <= '0;
      prev_pass  <= 1'b1;
      final_ph   <= 1'b0;
      trial_req  <= 1'b0;
      tap_sel    <= '0;
      chg_win    <= 1'b0;
      dly_en     <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      result_tap <= '0;
      degenerate <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          busy       <= 1'b1;
          done       <= 1'b0;
          degenerate <= 1'b0;
          dly_en     <= 1'b1;
          cur_tap    <= '0;
          target     <= '0;
          win_start  <= '0;
          fail_cnt   <= '0;
          prev_pass  <= 1'b1;
          final_ph   <= 1'b0;
          state      <= S_OPEN;
        end
        S_OPEN: begin
          chg_win <= 1'b1;
          state   <= S_WRITE;
        end
        S_WRITE: begin
          tap_sel <= target;
          state   <= S_CLOSE;
        end
        S_CLOSE: begin
          chg_win <= 1'b0;
          if (final_ph) begin
            busy       <= 1'b0;
            done       <= 1'b1;
            result_tap <= target;
            degenerate <= (fail_cnt == '0) || (fail_cnt == FULL_CNT);
            state      <= S_IDLE;
          end else begin
            trial_req <= 1'b1;
            state     <= S_TRIAL;
          end
        end
        S_TRIAL: if (accept) begin
          trial_req <= 1'b0;
          prev_pass <= trial_pass;
          if (trial_pass && !prev_pass) win_start <= cur_tap;
          if (!trial_pass) fail_cnt <= fail_cnt + 1'b1;
          if (cur_tap == LAST_TAP) begin
            state <= S_CALC;
          end else begin
            cur_tap <= cur_tap + 1'b1;
            target  <= cur_tap + 1'b1;
            state   <= S_OPEN;
          end
        end
        S_CALC: begin
          target   <= centre;
          final_ph <= 1'b1;
          state    <= S_OPEN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_tap_tuner_chk.sv
module rx_tap_tuner_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trial_valid,
  input logic             trial_req,
  input logic [TAP_W-1:0] tap_sel,
  input logic             chg_win,
  input logic             dly_en,
  input logic             busy,
  input logic             done
);
  // R2
  en_covers_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dly_en);
  // R3
  tap_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_sel) |-> (chg_win && $past(chg_win)));
  // R3
  close_after_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_sel) |=> !chg_win);
  // R3
  req_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req |-> (!chg_win && busy));
  // R4
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_req && !trial_valid) |=> trial_req);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !trial_req));
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

bind rx_tap_tuner rx_tap_tuner_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trial_valid(trial_valid), .trial_req(trial_req),
  .tap_sel(tap_sel), .chg_win(chg_win), .dly_en(dly_en), .busy(busy),
  .done(done)
);

// File: tb/test_rx_tap_tuner.sv
`timescale 1ns/1ps
module test_rx_tap_tuner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic trial_valid = 1'b0;
  logic trial_pass = 1'b0;
  logic trial_req, chg_win, dly_en, busy, done, degenerate;
  logic [4:0] tap_sel, result_tap;
  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rx_tap_tuner i_rx_tap_tuner (
    .clk(clk), .rst_n(rst_n), .start(start), .trial_valid(trial_valid),
    .trial_pass(trial_pass), .trial_req(trial_req), .tap_sel(tap_sel),
    .chg_win(chg_win), .dly_en(dly_en), .busy(busy), .done(done),
    .result_tap(result_tap), .degenerate(degenerate)
  );

  localparam logic [31:0] PAT [0:7] = '{
    32'h0000FF00, 32'hF000000F, 32'h000007E0, 32'hFFFFFFFF,
    32'h00000000, 32'h80000000, 32'h00000007, 32'h3FF0000C
  };
  localparam logic [5:0] EXP [0:7] = '{
    {5'd12, 1'b0}, {5'd0, 1'b0}, {5'd8, 1'b0}, {5'd16, 1'b1},
    {5'd0, 1'b1},  {5'd31, 1'b0}, {5'd1, 1'b0}, {5'd26, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sweep(input logic [31:0] pat, input bit poke_start,
                       output int order_err, output int win_err);
    order_err = 0;
    win_err = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int t = 0; t < 32; t++) begin
      int w = 0;
      while (!trial_req && w < 40) begin
        @(negedge clk);
        if (chg_win && !busy) win_err++;
        w++;
      end
      if (tap_sel != 5'(t) || chg_win) order_err++;
      if (poke_start && t == 10) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      trial_valid = 1'b1;
      trial_pass = pat[t];
      @(negedge clk);
      trial_valid = 1'b0;
      if (trial_req) order_err++;
    end
    for (int w = 0; w < 40 && !done; w++) @(negedge clk);
  endtask

  initial begin
    int oe, we;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !dly_en && !chg_win && !trial_req, "R1 flags", busy, 0);
    chk(tap_sel == 0 && result_tap == 0 && !degenerate, "R1 values", tap_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: busy and delay enable on the accepting edge, no window yet
    chk(busy && dly_en && !chg_win, "R2 enable", dly_en, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      sweep(PAT[v], 1'b0, oe, we);
      // R4 order and handshake, R3 window separation
      chk(oe == 0, "R4 order", oe, 0);
      chk(we == 0, "R3 window", we, 0);
      // R5 R6 R8 result
      chk(result_tap == EXP[v][5:1] && tap_sel == EXP[v][5:1], "R6 result",
          result_tap, EXP[v][5:1]);
      chk(degenerate == EXP[v][0], "R8 degenerate", degenerate, EXP[v][0]);
      // R7
      chk(done && !busy, "R7 done", done, 1);
      // R2 enable held after sweep
      chk(dly_en, "R2 hold", dly_en, 1);
    end
    // R7: done holds while idle
    repeat (5) @(negedge clk);
    chk(done && result_tap == 5'd26, "R7 hold", done, 1);
    // R9: start during sweep ignored
    sweep(32'h0000FF00, 1'b1, oe, we);
    chk(oe == 0, "R9 order", oe, 0);
    chk(result_tap == 5'd12 && done && !busy, "R9 result", result_tap, 12);
    repeat (3) @(negedge clk);
    chk(!busy && done, "R9 no restart", busy, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule